// File: doc/BRIEF.md
# Fractional-Rate System Tick Counter

This block keeps a free-running 64-bit system count that advances at a programmable tick rate slower than the clock that runs it. Rather than dividing the clock by an integer, it adds a 32-bit phase increment to a phase accumulator on every running cycle. Each carry out of the accumulator's top bit advances the count by one. Software programs the increment as 2^32 × tick_rate / clock_rate, so rates that do not divide the clock evenly still average out exactly.

A small register port lets software do the following:
- enable counting, and ask that it stop while an external debug-halt input is high;
- raise a frequency-change request and see it acknowledged;
- program the increment;
- store a nominal-frequency word that only software reads;
- read the count;
- add an arbitrary 64-bit value to the count.

Writes take effect at the clock edge where `wr_en_i` is high. Reads are combinational from `rd_addr_i`. The count is also driven out on a dedicated port. The register port is plain and never stalls, so there is no back-pressure to manage.

Top module: `tick_counter`

## Requirements
- R1: Reset (synchronous, active high) clears the count, the phase accumulator, the increment register, the frequency word and all control bits; every register then reads zero and the status outputs are low.
- R2: Control bit 0 enables counting; while it is clear the count holds its value, apart from writes to the add register.
- R3: On each running cycle the 32-bit increment is added to the 32-bit phase accumulator, and the count rises by one on exactly the cycles where that addition carries out; starting from zero phase, after N running cycles the count equals floor(N × increment / 2^32), and an increment of zero never advances it.
- R4: With control bit 1 set, counting and the phase accumulator freeze while `dbg_halt_i` is high, and status bit 1 and `dbg_halted_o` read 1 for as long as the counter is enabled and frozen this way; with control bit 1 clear, `dbg_halt_i` has no effect.
- R5: Control bit 8 is a frequency-change request; its acknowledge (status bit 8 and `fc_ack_o`) rises one cycle after the request bit is written to 1 and falls one cycle after it is written to 0.
- R6: A write to the add register adds the written 64-bit value to the count, modulo 2^64, in the same cycle as any carry increment, so both take effect; this works whether or not counting is enabled.
- R7: Register addresses are 0 control, 1 status, 2 increment, 3 frequency word, 4 count, 5 add. Control reads back only bits 0, 1 and 8, with other bits zero. Increment and frequency word read back as written. The add register reads zero. Writes to status and count are ignored.
- R8: The frequency word has no effect on counting.
- R9: `count_o` always equals the value read at the count address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast I/O clock |
| rst_i | input | 1 | Synchronous reset, active high |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W | Register write address |
| wr_data_i | input | CNT_W | Register write data |
| rd_addr_i | input | ADDR_W | Register read address |
| rd_data_o | output | CNT_W | Combinational read data |
| dbg_halt_i | input | 1 | Debug-halt request from the system |
| count_o | output | CNT_W | Current count value |
| dbg_halted_o | output | 1 | Counter frozen by debug halt |
| fc_ack_o | output | 1 | Frequency-change acknowledge |

## Verification
On every cycle the assertions check the following. The count holds while it is disabled, debug-frozen or given a zero increment. It never steps by more than one without an add write. An add write lands together with at most one carry. The acknowledge follows the request one cycle later. Only the bench's scenarios can show that the average rate is exactly floor(N × increment / 2^32) for several increments, including the 1/3-style inexact one. The same goes for register read-back and masking, writes that are ignored, wrap of the add modulo 2^64, and the phase carried correctly across a debug freeze.

// File: rtl/tick_pkg.sv
package tick_pkg;
  // Register addresses
  localparam int REG_CTRL  = 0;
  localparam int REG_STAT  = 1;
  localparam int REG_RATE  = 2;
  localparam int REG_FREQ  = 3;
  localparam int REG_COUNT = 4;
  localparam int REG_ADD   = 5;

  // Control / status bit positions
  localparam int BIT_EN   = 0;
  localparam int BIT_HDBG = 1;
  localparam int BIT_FC   = 8;

  typedef struct packed {
    logic fc_req;
    logic hdbg;
    logic en;
  } ctrl_t;
endpackage

// File: rtl/tick_regs.sv
module tick_regs
  import tick_pkg::*;
#(
  parameter int FRAC_W = 32,
  parameter int FREQ_W = 32,
  parameter int DATA_W = 64,
  parameter int ADDR_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              dbg_halt_i,
  output ctrl_t             ctrl_o,
  output logic [FRAC_W-1:0] rate_o,
  output logic [FREQ_W-1:0] freq_o,
  output logic              fc_ack_o,
  output logic              run_o,
  output logic              dbg_halted_o,
  output logic              add_we_o,
  output logic [DATA_W-1:0] add_val_o
);
  ctrl_t             ctrl_q;
  logic [FRAC_W-1:0] rate_q;
  logic [FREQ_W-1:0] freq_q;
  logic              ack_q;
  logic              hit_ctrl, hit_rate, hit_freq, frozen;

  assign hit_ctrl = wr_en_i && (wr_addr_i == ADDR_W'(REG_CTRL));
  assign hit_rate = wr_en_i && (wr_addr_i == ADDR_W'(REG_RATE));
  assign hit_freq = wr_en_i && (wr_addr_i == ADDR_W'(REG_FREQ));

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      ctrl_q <= '0;
      rate_q <= '0;
      freq_q <= '0;
      ack_q  <= 1'b0;
    end else begin
      if (hit_ctrl) begin
        ctrl_q.en     <= wr_data_i[BIT_EN];
        ctrl_q.hdbg   <= wr_data_i[BIT_HDBG];
        ctrl_q.fc_req <= wr_data_i[BIT_FC];
      end
      if (hit_rate) rate_q <= wr_data_i[FRAC_W-1:0];
      if (hit_freq) freq_q <= wr_data_i[FREQ_W-1:0];
      // acknowledge trails the stored request by one cycle
      ack_q <= ctrl_q.fc_req;
    end
  end

  assign frozen       = ctrl_q.hdbg && dbg_halt_i;
  assign run_o        = ctrl_q.en && !frozen;
  assign dbg_halted_o = ctrl_q.en && frozen;
  assign ctrl_o       = ctrl_q;
  assign rate_o       = rate_q;
  assign freq_o       = freq_q;
  assign fc_ack_o     = ack_q;
  assign add_we_o     = wr_en_i && (wr_addr_i == ADDR_W'(REG_ADD));
  assign add_val_o    = wr_data_i;
endmodule

// File: rtl/tick_phase_acc.sv
module tick_phase_acc #(
  parameter int FRAC_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              run_i,
  input  logic [FRAC_W-1:0] rate_i,
  output logic              carry_o
);
  localparam int SUM_W = FRAC_W + 1;

  logic [FRAC_W-1:0] phase_q;
  logic [SUM_W-1:0]  sum;

  assign sum     = {1'b0, phase_q} + {1'b0, rate_i};
  assign carry_o = run_i && sum[SUM_W-1];

  always_ff @(posedge clk_i) begin
    if (rst_i)      phase_q <= '0;
    else if (run_i) phase_q <= sum[FRAC_W-1:0];
  end
endmodule

// File: rtl/tick_count.sv
module tick_count #(
  parameter int CNT_W = 64
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             inc_i,
  input  logic             add_we_i,
  input  logic [CNT_W-1:0] add_val_i,
  output logic [CNT_W-1:0] count_o
);
  logic [CNT_W-1:0] count_q, addend;

  // carry and add write merge into one adder so both land together
  assign addend = (add_we_i ? add_val_i : '0) + CNT_W'(inc_i);

  always_ff @(posedge clk_i) begin
    if (rst_i) count_q <= '0;
    else       count_q <= count_q + addend;
  end

  assign count_o = count_q;
endmodule

// File: rtl/tick_counter.sv
module tick_counter
  import tick_pkg::*;
#(
  parameter int CNT_W  = 64,
  parameter int FRAC_W = 32,
  parameter int FREQ_W = 32,
  parameter int ADDR_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [CNT_W-1:0]  wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [CNT_W-1:0]  rd_data_o,
  input  logic              dbg_halt_i,
  output logic [CNT_W-1:0]  count_o,
  output logic              dbg_halted_o,
  output logic              fc_ack_o
);
  ctrl_t             ctrl_q;
  logic [FRAC_W-1:0] rate_q;
  logic [FREQ_W-1:0] freq_q;
  logic              run, carry, add_we;
  logic [CNT_W-1:0]  add_val, count_q;

  tick_regs #(
    .FRAC_W(FRAC_W), .FREQ_W(FREQ_W), .DATA_W(CNT_W), .ADDR_W(ADDR_W)
  ) u_regs (
    .clk_i(clk_i), .rst_i(rst_i),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .dbg_halt_i(dbg_halt_i),
    .ctrl_o(ctrl_q), .rate_o(rate_q), .freq_o(freq_q),
    .fc_ack_o(fc_ack_o), .run_o(run), .dbg_halted_o(dbg_halted_o),
    .add_we_o(add_we), .add_val_o(add_val)
  );

  tick_phase_acc #(.FRAC_W(FRAC_W)) u_phase (
    .clk_i(clk_i), .rst_i(rst_i), .run_i(run), .rate_i(rate_q),
    .carry_o(carry)
  );

  tick_count #(.CNT_W(CNT_W)) u_count (
    .clk_i(clk_i), .rst_i(rst_i), .inc_i(carry),
    .add_we_i(add_we), .add_val_i(add_val), .count_o(count_q)
  );

  always_comb begin
    rd_data_o = '0;
    case (rd_addr_i)
      ADDR_W'(REG_CTRL): begin
        rd_data_o[BIT_EN]   = ctrl_q.en;
        rd_data_o[BIT_HDBG] = ctrl_q.hdbg;
        rd_data_o[BIT_FC]   = ctrl_q.fc_req;
      end
      ADDR_W'(REG_STAT): begin
        rd_data_o[BIT_HDBG] = dbg_halted_o;
        rd_data_o[BIT_FC]   = fc_ack_o;
      end
      ADDR_W'(REG_RATE):  rd_data_o[FRAC_W-1:0] = rate_q;
      ADDR_W'(REG_FREQ):  rd_data_o[FREQ_W-1:0] = freq_q;
      ADDR_W'(REG_COUNT): rd_data_o = count_q;
      default:            rd_data_o = '0;
    endcase
  end

  assign count_o = count_q;
endmodule

// File: rtl/tick_counter_chk.sv
module tick_counter_chk
  import tick_pkg::*;
#(
  parameter int CNT_W  = 64,
  parameter int FRAC_W = 32
) (
  input logic              clk_i,
  input logic              rst_i,
  input ctrl_t             ctrl_q,
  input logic [FRAC_W-1:0] rate_q,
  input logic              add_we,
  input logic [CNT_W-1:0]  add_val,
  input logic              dbg_halt_i,
  input logic [CNT_W-1:0]  count_o,
  input logic              fc_ack_o
);
  AST_HOLD_DISABLED: assert property (@(posedge clk_i) disable iff (rst_i)
    (!ctrl_q.en && !add_we) |=> $stable(count_o)); // R2

  AST_STEP_AT_MOST_ONE: assert property (@(posedge clk_i) disable iff (rst_i)
    !add_we |=> ((count_o - $past(count_o)) <= CNT_W'(1))); // R3

  AST_ZERO_RATE_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
    ((rate_q == '0) && !add_we) |=> $stable(count_o)); // R3

  AST_DEBUG_FREEZE: assert property (@(posedge clk_i) disable iff (rst_i)
    (ctrl_q.hdbg && dbg_halt_i && !add_we) |=> $stable(count_o)); // R4

  AST_ACK_RISE: assert property (@(posedge clk_i) disable iff (rst_i)
    ctrl_q.fc_req |=> fc_ack_o); // R5

  AST_ACK_FALL: assert property (@(posedge clk_i) disable iff (rst_i)
    !ctrl_q.fc_req |=> !fc_ack_o); // R5

  AST_ADD_MERGE: assert property (@(posedge clk_i) disable iff (rst_i)
    add_we |=> ((count_o - $past(count_o) - $past(add_val)) <= CNT_W'(1))); // R6
endmodule

bind tick_counter tick_counter_chk #(.CNT_W(CNT_W), .FRAC_W(FRAC_W)) u_chk (
  .clk_i(clk_i), .rst_i(rst_i), .ctrl_q(ctrl_q), .rate_q(rate_q),
  .add_we(add_we), .add_val(add_val), .dbg_halt_i(dbg_halt_i),
  .count_o(count_o), .fc_ack_o(fc_ack_o)
);

// File: tb/tb_tick_counter.sv
`timescale 1ns/1ps
module tb_tick_counter;
  localparam int CNT_W = 64;
  localparam int ADDR_W = 3;

  logic              clk_i = 1'b0;
  logic              rst_i = 1'b1;
  logic              wr_en_i = 1'b0;
  logic [ADDR_W-1:0] wr_addr_i = '0;
  logic [CNT_W-1:0]  wr_data_i = '0;
  logic [ADDR_W-1:0] rd_addr_i = '0;
  logic [CNT_W-1:0]  rd_data_o;
  logic              dbg_halt_i = 1'b0;
  logic [CNT_W-1:0]  count_o;
  logic              dbg_halted_o;
  logic              fc_ack_o;

  int checks = 0;
  int errors = 0;

  always #2 clk_i = ~clk_i;  // 250 MHz

  tick_counter dut (
    .clk_i(clk_i), .rst_i(rst_i), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o),
    .dbg_halt_i(dbg_halt_i), .count_o(count_o),
    .dbg_halted_o(dbg_halted_o), .fc_ack_o(fc_ack_o)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] model(input int n, input logic [31:0] inc);
    return (64'(n) * 64'(inc)) >> 32;
  endfunction

  // all tasks start and end just after a falling edge
  task automatic do_reset();
    rst_i = 1'b1; dbg_halt_i = 1'b0;
    repeat (3) @(negedge clk_i);
    rst_i = 1'b0;
  endtask

  task automatic wr(input int addr, input logic [63:0] data);
    wr_en_i = 1'b1; wr_addr_i = ADDR_W'(addr); wr_data_i = data;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input int addr, output logic [63:0] data);
    rd_addr_i = ADDR_W'(addr);
    #1 data = rd_data_o;
    @(negedge clk_i);
  endtask

  task automatic t_reset();
    logic [63:0] v;
    do_reset();
    for (int a = 0; a < 6; a++) begin
      rd(a, v);
      check("R1 register zero after reset", v, 0);
    end
    check("R1 dbg_halted_o low", 64'(dbg_halted_o), 0);
    check("R1 fc_ack_o low", 64'(fc_ack_o), 0);
  endtask

  task automatic t_rate(input logic [31:0] inc, input int n);
    logic [63:0] v;
    do_reset();
    wr(2, 64'(inc));
    wr(0, 64'h1);
    repeat (n) @(negedge clk_i);
    rd(4, v);  // one more running edge passes inside rd
    check("R3 count after running cycles", v, model(n, inc));
    check("R9 count_o matches register", count_o, model(n + 1, inc));
  endtask

  task automatic t_hold();
    logic [63:0] v;
    do_reset();
    wr(2, 64'h4000_0000);
    wr(0, 64'h1);
    repeat (20) @(negedge clk_i);
    wr(0, 64'h0);  // one more running edge during this write
    check("R2 count at disable", count_o, model(21, 32'h4000_0000));
    repeat (10) @(negedge clk_i);
    check("R2 count holds while disabled", count_o, model(21, 32'h4000_0000));
    wr(2, 64'h0);
    wr(0, 64'h1);
    repeat (15) @(negedge clk_i);
    rd(4, v);
    check("R3 zero increment never advances", v, model(21, 32'h4000_0000));
  endtask

  task automatic t_debug();
    logic [63:0] v;
    do_reset();
    dbg_halt_i = 1'b1;
    wr(2, 64'h8000_0000);
    wr(0, 64'h3);
    repeat (10) @(negedge clk_i);
    check("R4 frozen while halted", count_o, 0);
    rd(1, v);
    check("R4 status halted bit", v, 64'h2);
    check("R4 dbg_halted_o", 64'(dbg_halted_o), 1);
    dbg_halt_i = 1'b0;
    repeat (8) @(negedge clk_i);
    check("R4 resumes after release", count_o, 4);
    dbg_halt_i = 1'b1;
    repeat (5) @(negedge clk_i);
    check("R4 frozen again", count_o, 4);
    wr(0, 64'h1);  // edge sees old halt setting: no step
    repeat (6) @(negedge clk_i);
    check("R4 halt input ignored when bit clear", count_o, 7);
    check("R4 dbg_halted_o low when bit clear", 64'(dbg_halted_o), 0);
  endtask

  task automatic t_fc();
    logic [63:0] v;
    do_reset();
    wr(0, 64'h100);
    check("R5 ack not yet raised", 64'(fc_ack_o), 0);
    @(negedge clk_i);
    check("R5 ack raised one cycle later", 64'(fc_ack_o), 1);
    rd(1, v);
    check("R5 status ack bit", v, 64'h100);
    wr(0, 64'h0);
    check("R5 ack still high", 64'(fc_ack_o), 1);
    @(negedge clk_i);
    check("R5 ack dropped one cycle later", 64'(fc_ack_o), 0);
  endtask

  task automatic t_add();
    do_reset();
    wr(2, 64'h8000_0000);
    wr(0, 64'h1);
    @(negedge clk_i);
    wr(5, 64'd1000);  // carry lands on the same edge
    check("R6 add and carry combine", count_o, 64'd1001);
    do_reset();
    wr(5, 64'hFFFF_FFFF_FFFF_FFF0);
    check("R6 add while disabled", count_o, 64'hFFFF_FFFF_FFFF_FFF0);
    wr(5, 64'h20);
    check("R6 add wraps modulo 2^64", count_o, 64'h10);
  endtask

  task automatic t_map();
    logic [63:0] v;
    do_reset();
    wr(0, '1);
    rd(0, v);
    check("R7 control readback masked", v, 64'h103);
    wr(0, 64'h0);
    wr(2, 64'hABCD_1234_5555_5556);
    rd(2, v);
    check("R7 increment readback", v, 64'h5555_5556);
    wr(3, 64'd1_000_000);
    rd(3, v);
    check("R7 frequency word readback", v, 64'd1_000_000);
    wr(5, 64'h7);
    rd(5, v);
    check("R7 add register reads zero", v, 0);
    wr(4, 64'h55);
    rd(4, v);
    check("R7 count write ignored", v, 64'h7);
    wr(1, 64'h102);
    rd(1, v);
    check("R7 status write ignored", v, 0);
    do_reset();
    wr(3, 64'd1_000_000);
    wr(0, 64'h1);
    repeat (25) @(negedge clk_i);
    check("R8 frequency word does not count", count_o, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk_i);
    t_reset();
    t_rate(32'h4000_0000, 20);
    t_rate(32'h5555_5556, 30);
    t_rate(32'hFFFF_FFFF, 100);
    t_rate(32'h0001_0000, 300000 / 1000);
    t_hold();
    t_debug();
    t_fc();
    t_add();
    t_map();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule